// File: doc/BRIEF.md
# Dual Edge-Qualified Decade/Binary Counter

This block contains two independent up counters. Each counter is four bits wide and has its own count pin, enable pin and active-high clear. A build-time parameter chooses the counting mode. In binary mode each counter runs 0 to 15. In decimal mode it runs 0 to 9. Both pins are slow external levels. They are synchronized to a fast system clock, and increments are taken from edges seen in the synchronized samples. Because of this, the count and enable roles can be swapped when several counters are chained: one stage can be clocked by a rising edge on its count pin, or by a falling edge on its enable pin.

All four bits of a counter change on the same system clock edge. In decimal mode, a counter that holds an illegal code (10 to 15) returns to a legal code within two increments. A preload port lets verification place any code, including the illegal ones, into a counter. A terminal-count flag per counter marks the highest legal value, so a following stage can be gated.

Top module: `dual_edge_counter`

## Requirements
- R1: While the system reset `rst_n` is low, and on the first cycle after it is released, every counter output reads 0 and no increment occurs.
- R2: A high `ch_clr[n]` sets counter n to 0 at the next clock edge. It overrides both preload and increment, and it leaves the other counter unchanged.
- R3: A rising edge on `cnt_pin[n]` increments counter n by one if `en_pin[n]` was high in the previous synchronized sample. The new value appears on `q` at the third rising clock edge after the pin change.
- R4: A falling edge on `en_pin[n]` increments counter n by one if `cnt_pin[n]` was low in the previous synchronized sample. The latency is the same as in R3.
- R5: The following leave the counter unchanged: a falling edge on the count pin, a rising edge on the enable pin, a count-pin rise while enable was low, and an enable-pin fall while the count pin was high.
- R6: When a qualifying count-pin rise and a qualifying enable-pin fall occur in the same synchronized sample, the counter advances by exactly one.
- R7: In binary mode (`DECIMAL`=0) an increment from 15 gives 0, and an increment from any other value gives that value plus one.
- R8: In decimal mode (`DECIMAL`=1) an increment from 9 gives 0, and an increment from 0 to 8 gives that value plus one.
- R9: In decimal mode an increment from an even illegal code (10, 12, 14) gives that code plus one, and an increment from an odd illegal code (11, 13, 15) gives 0. Every illegal code is therefore left within two increments.
- R10: A high `load[n]` writes `load_val[4n+3:4n]` into counter n at the next clock edge, unless `ch_clr[n]` is high at the same time.
- R11: `tc[n]` is high exactly when counter n equals 9 in decimal mode, or 15 in binary mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than any pin activity |
| rst_n | input | 1 | Active-low system reset |
| ch_clr | input | NUM_CH | Active-high clear, one bit per counter |
| cnt_pin | input | NUM_CH | Count pins, asynchronous |
| en_pin | input | NUM_CH | Enable pins, asynchronous |
| load | input | NUM_CH | Preload strobes |
| load_val | input | NUM_CH*CNT_W | Preload values, counter n in bits [4n+3:4n] |
| q | output | NUM_CH*CNT_W | Counter values, counter n in bits [4n+3:4n] |
| tc | output | NUM_CH | Terminal-count flags |

## Verification
On every cycle, assertions check the following: a clear forces zero, with no qualifying edge the count holds, an increment moves by exactly one step modulo the counter's range, an illegal decimal code can only step forward or fall to zero, and an increment pulse is only produced when a synchronized pin has changed. The bench scenarios are needed for the rest: the three-cycle pin-to-output latency, the exact rules for which edge qualifies, the coincident-edge case, the illegal-code exit sequence, and the independence of the two counters. For these, a reference model is compared against both a decimal and a binary instance under seeded random pin activity.

// File: rtl/dual_edge_counter_pkg.sv
`timescale 1ns/1ps
package dual_edge_counter_pkg;
   // Edge events found for one counter in one system cycle
   typedef struct packed {
      logic cnt_rise;   // qualified rise on the count pin
      logic en_fall;    // qualified fall on the enable pin
   } edge_ev_t;

   localparam int unsigned DEC_LAST = 9;
endpackage

// File: rtl/pin_edge_qual.sv
`timescale 1ns/1ps
module pin_edge_qual #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cnt_pin,
   input  logic en_pin,
   output dual_edge_counter_pkg::edge_ev_t ev,
   output logic step
);
   import dual_edge_counter_pkg::*;

   localparam int unsigned PW = SYNC_STAGES + 1;

   logic [PW-1:0] c_pipe;
   logic [PW-1:0] e_pipe;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pin_edge_qual: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_pipe <= '0;
         e_pipe <= '0;
      end else begin
         c_pipe <= {c_pipe[PW-2:0], cnt_pin};
         e_pipe <= {e_pipe[PW-2:0], en_pin};
      end
   end

   logic c_now, c_old, e_now, e_old;
   assign c_now = c_pipe[SYNC_STAGES-1];
   assign c_old = c_pipe[SYNC_STAGES];
   assign e_now = e_pipe[SYNC_STAGES-1];
   assign e_old = e_pipe[SYNC_STAGES];

   // Qualification uses the previous sample of the partner pin
   always_comb begin
      ev.cnt_rise = c_now & ~c_old & e_old;
      ev.en_fall  = e_old & ~e_now & ~c_old;
   end

   assign step = ev.cnt_rise | ev.en_fall;

   // R3 / R4: a pulse needs a change seen on a synchronized pin
   assert_step_has_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (c_pipe[SYNC_STAGES-1] != c_pipe[SYNC_STAGES]) ||
               (e_pipe[SYNC_STAGES-1] != e_pipe[SYNC_STAGES]));
endmodule

// File: rtl/count_stage.sv
`timescale 1ns/1ps
module count_stage #(
   parameter int unsigned CNT_W   = 4,
   parameter bit          DECIMAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   output logic [CNT_W-1:0] q,
   output logic             tc
);
   import dual_edge_counter_pkg::*;

   localparam logic [CNT_W-1:0] TOP_V = DECIMAL ? CNT_W'(DEC_LAST)
                                                : {CNT_W{1'b1}};

   logic [CNT_W-1:0] nxt;

   generate
      if (DECIMAL) begin : g_dec
         if (CNT_W != 4) begin : g_bad_w
            $error("count_stage: decimal mode needs CNT_W of 4");
         end
         // Odd illegal codes drop to zero, even ones step up first
         always_comb begin
            if (q == TOP_V || (q > TOP_V && q[0]))
               nxt = '0;
            else
               nxt = q + 1'b1;
         end
      end else begin : g_bin
         always_comb nxt = q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (clr)   q <= '0;
      else if (load)  q <= load_val;
      else if (step)  q <= nxt;
   end

   assign tc = (q == TOP_V);

   assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q == '0));

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load && !step) |=> $stable(q));

   assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && load) |=> (q == $past(load_val)));

   generate
      if (DECIMAL) begin : g_dec_chk
         assert_one_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && !load && step) |=> (q == $past(q) + 1'b1) || (q == '0));
         assert_illegal_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && !load && step && q > TOP_V) |=> (q == '0) || (q[0] && q > TOP_V));
      end else begin : g_bin_chk
         assert_one_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && !load && step) |=> (q == $past(q) + 1'b1));
      end
   endgenerate
endmodule

// File: rtl/dual_edge_counter.sv
`timescale 1ns/1ps
module dual_edge_counter #(
   parameter int unsigned NUM_CH      = 2,
   parameter int unsigned CNT_W       = 4,
   parameter bit          DECIMAL     = 1'b1,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CH-1:0]       ch_clr,
   input  logic [NUM_CH-1:0]       cnt_pin,
   input  logic [NUM_CH-1:0]       en_pin,
   input  logic [NUM_CH-1:0]       load,
   input  logic [NUM_CH*CNT_W-1:0] load_val,
   output logic [NUM_CH*CNT_W-1:0] q,
   output logic [NUM_CH-1:0]       tc
);
   import dual_edge_counter_pkg::*;

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("dual_edge_counter: NUM_CH must be at least 1");
      end

      for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
         edge_ev_t ev;
         logic     step;

         pin_edge_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt_pin (cnt_pin[n]),
            .en_pin  (en_pin[n]),
            .ev      (ev),
            .step    (step)
         );

         count_stage #(.CNT_W(CNT_W), .DECIMAL(DECIMAL)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (ch_clr[n]),
            .load     (load[n]),
            .load_val (load_val[n*CNT_W +: CNT_W]),
            .step     (step),
            .q        (q[n*CNT_W +: CNT_W]),
            .tc       (tc[n])
         );

         // R6: a coincident pair of qualifying edges still gives one pulse
         assert_pair_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (ev.cnt_rise && ev.en_fall) |-> step);
      end
   endgenerate
endmodule

// File: tb/dual_edge_counter_bench.sv
`timescale 1ns/1ps
module dual_edge_counter_bench;
   localparam int NCH = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ch_clr = '0, cnt_pin = '0, en_pin = '0, load = '0;
   logic [7:0] load_val = '0;
   logic [7:0] q_dec, q_bin;
   logic [1:0] tc_dec, tc_bin;

   int n_chk = 0;
   int n_err = 0;

   logic [3:0] ref_dec [NCH];
   logic [3:0] ref_bin [NCH];
   logic       pc [NCH];
   logic       pe [NCH];

   always #10 clk = ~clk;

   dual_edge_counter #(.DECIMAL(1'b1)) u_dual_edge_counter (
      .clk(clk), .rst_n(rst_n), .ch_clr(ch_clr), .cnt_pin(cnt_pin), .en_pin(en_pin),
      .load(load), .load_val(load_val), .q(q_dec), .tc(tc_dec));

   dual_edge_counter #(.DECIMAL(1'b0)) u_dual_edge_counter_bin (
      .clk(clk), .rst_n(rst_n), .ch_clr(ch_clr), .cnt_pin(cnt_pin), .en_pin(en_pin),
      .load(load), .load_val(load_val), .q(q_bin), .tc(tc_bin));

   function automatic logic [3:0] dec_next(input logic [3:0] v);
      if (v == 4'd9) return 4'd0;
      if (v > 4'd9 && v[0]) return 4'd0;
      return v + 4'd1;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_all(input string tag);
      for (int n = 0; n < NCH; n++) begin
         chk({tag, " dec q"}, q_dec[n*4 +: 4], ref_dec[n]);
         chk({tag, " bin q"}, q_bin[n*4 +: 4], ref_bin[n]);
         chk("R11 dec tc", tc_dec[n], ref_dec[n] == 4'd9);
         chk("R11 bin tc", tc_bin[n], ref_bin[n] == 4'd15);
      end
   endtask

   // Called at a negedge: change pins, predict, then check three edges later
   task automatic drive_pins(input logic [1:0] c, input logic [1:0] e);
      string tag;
      tag = "R5";
      for (int n = 0; n < NCH; n++) begin
         logic rise, fall;
         rise = c[n] && !pc[n] && pe[n];
         fall = !e[n] && pe[n] && !pc[n];
         if (rise && fall)   tag = "R6";
         else if (rise)      tag = "R3";
         else if (fall && tag != "R6") tag = "R4";
         if (rise || fall) begin
            if (ref_dec[n] > 4'd9) tag = "R9";
            ref_dec[n] = dec_next(ref_dec[n]);
            ref_bin[n] = ref_bin[n] + 4'd1;
         end
         pc[n] = c[n];
         pe[n] = e[n];
      end
      cnt_pin = c;
      en_pin  = e;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_all(tag);
   endtask

   task automatic do_load(input logic [1:0] sel, input logic [3:0] v0, input logic [3:0] v1);
      load = sel;
      load_val = {v1, v0};
      if (sel[0]) begin ref_dec[0] = v0; ref_bin[0] = v0; end
      if (sel[1]) begin ref_dec[1] = v1; ref_bin[1] = v1; end
      @(negedge clk);
      load = '0;
      chk_all("R10");
   endtask

   task automatic do_clear(input logic [1:0] sel, input logic with_load);
      ch_clr = sel;
      load = with_load ? 2'b11 : 2'b00;
      load_val = 8'h77;
      for (int n = 0; n < NCH; n++) begin
         if (sel[n]) begin ref_dec[n] = 0; ref_bin[n] = 0; end
         else if (with_load) begin ref_dec[n] = 4'd7; ref_bin[n] = 4'd7; end
      end
      @(negedge clk);
      ch_clr = '0;
      load = '0;
      chk_all("R2");
   endtask

   // A full count-pin pulse: rise (counts if enabled) then fall
   task automatic pulse_cnt(input int n);
      logic [1:0] c;
      c = cnt_pin; c[n] = 1'b1;
      drive_pins(c, en_pin);
      c[n] = 1'b0;
      drive_pins(c, en_pin);
   endtask

   initial begin : watchdog
      #(200000 * 20);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end

   initial begin : main
      int unused_seed;
      unused_seed = $urandom(32'h5EED_0042);
      for (int n = 0; n < NCH; n++) begin
         ref_dec[n] = 0; ref_bin[n] = 0; pc[n] = 0; pe[n] = 0;
      end
      @(negedge clk);
      chk_all("R1");
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_all("R1");

      // R3 / R8 / R7: enable high, pulse count pin through a wrap
      drive_pins(2'b00, 2'b11);
      for (int i = 0; i < 17; i++) pulse_cnt(0);
      // R4: count pin low, toggle enable to clock channel 1
      for (int i = 0; i < 3; i++) begin
         drive_pins(2'b00, 2'b01);
         drive_pins(2'b00, 2'b11);
      end
      // R5: count rise with enable low, enable fall with count high
      drive_pins(2'b00, 2'b00);
      drive_pins(2'b11, 2'b00);
      drive_pins(2'b11, 2'b11);
      drive_pins(2'b11, 2'b00);
      drive_pins(2'b00, 2'b00);
      // R6: coincident qualifying rise and fall
      drive_pins(2'b00, 2'b11);
      drive_pins(2'b11, 2'b00);
      drive_pins(2'b00, 2'b00);

      // R9: every illegal decimal code walked out by count pulses
      drive_pins(2'b00, 2'b11);
      for (int v = 10; v < 16; v++) begin
         do_load(2'b01, 4'(v), 4'(25 - v));
         pulse_cnt(0);
         pulse_cnt(0);
      end
      // R10 / R2
      do_load(2'b11, 4'd9, 4'd15);
      do_clear(2'b01, 1'b0);
      do_clear(2'b10, 1'b1);

      // Seeded random pin traffic with occasional preload and clear
      for (int i = 0; i < 400; i++) begin
         int r;
         r = $urandom_range(0, 99);
         if (r < 8)       do_load(2'($urandom_range(1, 3)), 4'($urandom), 4'($urandom));
         else if (r < 11) do_clear(2'($urandom_range(1, 3)), 1'($urandom));
         else             drive_pins(2'($urandom), 2'($urandom));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end
endmodule